// File: doc/BRIEF.md
# Interrupt Status and Control Register File with Bit Set/Clear Aliases

This block is the register file of a two-wire bus controller. It keeps three registers: a control register whose top bit is a soft reset, an interrupt register that holds eight event status bits together with their eight enables, and a queue-control register that holds a queue-run bit and a programmed-I/O queue mode bit. The bus engine itself sits outside this block. It reports events through a set of pulse inputs. The block merges the enabled status bits into one registered interrupt line.

Each register can be written at three addresses. The base offset replaces the stored value. Offset +4 ORs in the written ones. Offset +8 clears the written ones. Software can therefore change single bits without a read-modify-write.

The soft reset is a two-state machine:
- `SR_RUN` is the normal state.
- The transition `enter_hold` goes to `SR_HOLD`. It is taken on a base write with bit 31 at 1, or on a set-alias write with bit 31 at 1.
- In `SR_HOLD`, every other register is held at zero.
- The transition `leave_hold` returns to `SR_RUN`. It is taken on a base write with bit 31 at 0, or on a clear-alias write with bit 31 at 1.

Top module: `csr_irq_regs`

## Requirements
- R1: After reset, all readable registers are zero, and `irq`, `queue_run`, `pio_queue_mode` and `soft_reset` are all low.
- R2: The register selector is address bits 7:4: control is 0x00, interrupt is 0x10, queue control is 0x20. In the interrupt register, status bit n (n from 0 to 7) sits at bit n and its enable sits at bit n+8. The status bits are: 7 bus free, 6 engine done, 5 no acknowledge, 4 oversize, 3 early stop, 2 arbitration lost, 1 target stop, 0 target event. Bits 31:16 of the interrupt register read as zero. A write at the base offset (+0) replaces the register.
- R3: A write at offset +4 sets every bit that is written as 1. Bits written as 0 keep their value.
- R4: A write at offset +8 clears every bit that is written as 1. Bits written as 0 keep their value.
- R5: A pulse on `hw_evt[n]` sets status bit n of the interrupt register at the next clock edge.
- R6: When a hardware event and a clear-alias write hit the same status bit in the same cycle, the bit ends up set.
- R7: `irq` is the OR of all status bits ANDed with their enables. It is registered, so it changes one cycle after the register contents change.
- R8: Queue-control bit 5 drives `queue_run` and bit 2 drives `pio_queue_mode`. All other bits of that register read as zero.
- R9: Writing 1 to control bit 31 (base or +4) does three things: it raises `soft_reset`, it makes control read 0x8000_0000, and it clears the interrupt and queue-control registers at the same edge. `irq` is low from the cycle after.
- R10: While the soft reset is held, writes to the other registers and hardware events have no effect. The soft reset is released by a +8 write with bit 31 set, or by a base write with bit 31 at 0.
- R11: Offset +0xC and addresses with nonzero bits 1:0 have no effect on writes and read as zero. Reads at +4 and +8 return the base value. Unmapped selectors read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Combinational read data |
| hw_evt | input | 8 | Event pulses from the bus engine, one per status bit |
| irq | output | 1 | Registered interrupt request |
| queue_run | output | 1 | Queue-run control bit |
| pio_queue_mode | output | 1 | Programmed-I/O queue mode bit |
| soft_reset | output | 1 | High while the soft reset is held |

## Verification
A wrong merge of an alias write, a hardware event or a soft-reset clear shows up on `rd_data` right at the edge that makes it. A wrong status or enable bit also changes `irq` exactly one cycle later. A soft-reset state machine stuck in the wrong state is seen on `soft_reset` at once. It then shows as zeroed or unexpectedly writable interrupt and queue registers on the next write. The bench's behavioural model predicts the registers, `irq` and the queue outputs every clock, so any such error is caught within one or two cycles of its cause.

// File: rtl/csr_irq_pkg.sv
package csr_irq_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } alias_op_e;

    typedef enum logic {
        SR_RUN  = 1'b0,
        SR_HOLD = 1'b1
    } srst_state_e;

    localparam int REG_CTRL = 0;
    localparam int REG_INT  = 1;
    localparam int REG_QCTL = 2;

    localparam int SRST_BIT = 31;
    localparam int QRUN_BIT = 5;
    localparam int QPIO_BIT = 2;

endpackage

// File: rtl/csr_alias_reg.sv
module csr_alias_reg
    import csr_irq_pkg::*;
#(
    parameter int             W    = 16,
    parameter logic [W-1:0]   MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  alias_op_e    op,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    input  logic         clear_all,
    output logic [W-1:0] q
);

    logic [W-1:0] sw_val;
    logic [W-1:0] q_d;

    always_comb begin
        sw_val = q;
        if (we) begin
            unique case (op)
                OP_WRITE: sw_val = wdata;
                OP_SET:   sw_val = q | wdata;
                OP_CLEAR: sw_val = q & ~wdata;
                default:  sw_val = q;
            endcase
        end
        // hardware set is merged after software, so set beats clear
        q_d = clear_all ? '0 : ((sw_val | hw_set) & MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_d;
    end

    p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_SET && !clear_all)
        |=> ((q & $past(wdata & MASK)) == $past(wdata & MASK)));

    p_clr_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_CLEAR && !clear_all)
        |=> ((q & $past(wdata & ~hw_set)) == '0));

    p_hw_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|hw_set) && !clear_all)
        |=> ((q & $past(hw_set & MASK)) == $past(hw_set & MASK)));

    p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (q == '0));

endmodule

// File: rtl/csr_srst_fsm.sv
module csr_srst_fsm
    import csr_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  alias_op_e op,
    input  logic      wbit,
    output logic      hold,
    output logic      entering
);

    srst_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_RUN: begin
                // enter_hold
                if (we && wbit && (op == OP_WRITE || op == OP_SET))
                    state_d = SR_HOLD;
            end
            SR_HOLD: begin
                // leave_hold
                if (we && ((op == OP_WRITE && !wbit) || (op == OP_CLEAR && wbit)))
                    state_d = SR_RUN;
            end
            default: state_d = SR_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        hold     = (state_q == SR_HOLD);
        entering = (state_d == SR_HOLD);
    end

    p_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wbit && op == OP_SET) |=> hold);

    p_leave_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && we && wbit && op == OP_CLEAR) |=> !hold);

endmodule

// File: rtl/csr_irq_merge.sv
module csr_irq_merge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] status,
    input  logic [N-1:0] enable,
    output logic         irq
);

    logic [N-1:0] pend;

    for (genvar i = 0; i < N; i++) begin : g_pend
        assign pend[i] = status[i] & enable[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |pend;
    end

endmodule

// File: rtl/csr_irq_regs.sv
module csr_irq_regs
    import csr_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int N_IRQ  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [N_IRQ-1:0]  hw_evt,
    output logic              irq,
    output logic              queue_run,
    output logic              pio_queue_mode,
    output logic              soft_reset
);

    localparam int SEL_W = ADDR_W - 4;
    localparam int INT_W = 2 * N_IRQ;
    localparam logic [DATA_W-1:0] QMASK =
        (DATA_W'(1) << QRUN_BIT) | (DATA_W'(1) << QPIO_BIT);

    logic [SEL_W-1:0]  w_sel, r_sel;
    alias_op_e         w_op, r_op;
    logic              w_ok;
    logic              we_ctrl, we_int, we_qctl;
    logic              hold, entering;
    logic [INT_W-1:0]  int_q;
    logic [DATA_W-1:0] qctl_q;

    always_comb begin
        w_sel   = wr_addr[ADDR_W-1:4];
        w_op    = alias_op_e'(wr_addr[3:2]);
        w_ok    = wr_en && (wr_addr[1:0] == 2'b00) && (w_op != OP_NONE);
        we_ctrl = w_ok && (w_sel == SEL_W'(REG_CTRL));
        we_int  = w_ok && (w_sel == SEL_W'(REG_INT));
        we_qctl = w_ok && (w_sel == SEL_W'(REG_QCTL));
    end

    csr_srst_fsm u_srst (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (we_ctrl),
        .op       (w_op),
        .wbit     (wr_data[SRST_BIT]),
        .hold     (hold),
        .entering (entering)
    );

    csr_alias_reg #(.W(INT_W), .MASK({INT_W{1'b1}})) u_int (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we_int),
        .op        (w_op),
        .wdata     (wr_data[INT_W-1:0]),
        .hw_set    ({{N_IRQ{1'b0}}, hw_evt}),
        .clear_all (entering),
        .q         (int_q)
    );

    csr_alias_reg #(.W(DATA_W), .MASK(QMASK)) u_qctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we_qctl),
        .op        (w_op),
        .wdata     (wr_data),
        .hw_set    ('0),
        .clear_all (entering),
        .q         (qctl_q)
    );

    csr_irq_merge #(.N(N_IRQ)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (int_q[N_IRQ-1:0]),
        .enable (int_q[INT_W-1:N_IRQ]),
        .irq    (irq)
    );

    always_comb begin
        r_sel   = rd_addr[ADDR_W-1:4];
        r_op    = alias_op_e'(rd_addr[3:2]);
        rd_data = '0;
        if (rd_addr[1:0] == 2'b00 && r_op != OP_NONE) begin
            if (r_sel == SEL_W'(REG_CTRL))
                rd_data[SRST_BIT] = hold;
            else if (r_sel == SEL_W'(REG_INT))
                rd_data[INT_W-1:0] = int_q;
            else if (r_sel == SEL_W'(REG_QCTL))
                rd_data = qctl_q;
        end
        queue_run      = qctl_q[QRUN_BIT];
        pio_queue_mode = qctl_q[QPIO_BIT];
        soft_reset     = hold;
    end

    p_hold_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (int_q == '0 && qctl_q == '0));

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !irq);

    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|int_q[N_IRQ-1:0]));

endmodule

// File: tb/test_csr_irq_regs.sv
module test_csr_irq_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  hw_evt = '0;
    logic        irq, queue_run, pio_queue_mode, soft_reset;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    csr_irq_regs i_csr_irq_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .hw_evt(hw_evt), .irq(irq), .queue_run(queue_run),
        .pio_queue_mode(pio_queue_mode), .soft_reset(soft_reset)
    );

    // behavioural reference model
    bit        m_srst;
    bit [7:0]  m_st, m_en;
    bit [31:0] m_q;
    bit        m_irq;

    function automatic bit [31:0] m_read(input bit [7:0] a);
        if (a[1:0] != 0 || a[3:2] == 3) return 0;
        case (a[7:4])
            0: return {m_srst, 31'd0};
            1: return {16'd0, m_en, m_st};
            2: return m_q;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_srst = 0; m_st = 0; m_en = 0; m_q = 0; m_irq = 0;
        end else begin
            bit [15:0] v;
            m_irq = |(m_st & m_en);
            v = {m_en, m_st};
            if (wr_en && wr_addr[1:0] == 0 && wr_addr[3:2] != 3) begin
                case (wr_addr[7:4])
                    0: case (wr_addr[3:2])
                           0: m_srst = wr_data[31];
                           1: if (wr_data[31]) m_srst = 1;
                           default: if (wr_data[31]) m_srst = 0;
                       endcase
                    1: case (wr_addr[3:2])
                           0: v = wr_data[15:0];
                           1: v = v | wr_data[15:0];
                           default: v = v & ~wr_data[15:0];
                       endcase
                    2: case (wr_addr[3:2])
                           0: m_q = wr_data & 32'h24;
                           1: m_q = (m_q | wr_data) & 32'h24;
                           default: m_q = m_q & ~wr_data;
                       endcase
                    default: ;
                endcase
            end
            v[7:0] = v[7:0] | hw_evt;
            if (m_srst) begin v = 0; m_q = 0; end
            m_st = v[7:0]; m_en = v[15:8];
        end
    end

    task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the edge
    always begin
        @(posedge clk);
        #8;
        if (rst_n && !done) begin
            chk("R11 model readback", rd_data, m_read(rd_addr));
            chk("R7 model irq", {31'd0, irq}, {31'd0, m_irq});
            chk("R8 model queue_run", {31'd0, queue_run}, {31'd0, m_q[5]});
            chk("R8 model pio", {31'd0, pio_queue_mode}, {31'd0, m_q[2]});
            chk("R9 model soft_reset", {31'd0, soft_reset}, {31'd0, m_srst});
        end
    end

    task automatic wr_hw(input bit [7:0] a, input bit [31:0] d, input bit [7:0] h);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d; hw_evt = h;
        @(negedge clk);
        wr_en = 0; hw_evt = 0;
        #1;
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        wr_hw(a, d, 8'h00);
    endtask

    task automatic pulse(input bit [7:0] h);
        @(negedge clk);
        hw_evt = h;
        @(negedge clk);
        hw_evt = 0;
        #1;
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic rd_chk(input string tag, input bit [7:0] a, input bit [31:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        rd_chk("R1 ctrl", 8'h00, 0);
        rd_chk("R1 int", 8'h10, 0);
        rd_chk("R1 qctl", 8'h20, 0);
        chk("R1 outs", {irq, queue_run, pio_queue_mode, soft_reset}, 0);

        rd_addr = 8'h10;
        wr(8'h10, 32'h0000_A5C3);
        rd_chk("R2 base write", 8'h10, 32'h0000_A5C3);
        chk("R7 irq not yet", {31'd0, irq}, 0);
        tick();
        chk("R7 irq one cycle later", {31'd0, irq}, 1);

        wr(8'h18, 32'h0000_00C3);
        rd_chk("R4 clear alias", 8'h10, 32'h0000_A500);
        tick();
        chk("R7 irq drops", {31'd0, irq}, 0);

        wr(8'h14, 32'h0000_0004);
        rd_chk("R3 set alias", 8'h10, 32'h0000_A504);
        tick();
        chk("R7 irq arbitration lost", {31'd0, irq}, 1);

        pulse(8'h20);
        rd_chk("R5 hw event", 8'h10, 32'h0000_A524);

        wr_hw(8'h18, 32'h0000_0024, 8'h04);
        rd_chk("R6 set beats clear", 8'h10, 32'h0000_A504);

        wr(8'h1C, 32'h0000_FFFF);
        rd_chk("R11 offset C write", 8'h10, 32'h0000_A504);
        wr(8'h11, 32'h0000_FFFF);
        rd_chk("R11 unaligned write", 8'h10, 32'h0000_A504);
        rd_chk("R11 read set alias", 8'h14, 32'h0000_A504);
        rd_chk("R11 read clear alias", 8'h18, 32'h0000_A504);
        rd_chk("R11 read offset C", 8'h1C, 0);

        wr(8'h24, 32'hFFFF_FFFF);
        rd_chk("R8 qctl mask", 8'h20, 32'h0000_0024);
        chk("R8 outs set", {30'd0, queue_run, pio_queue_mode}, 3);
        wr(8'h28, 32'h0000_0020);
        rd_chk("R8 qctl clear run", 8'h20, 32'h0000_0004);
        chk("R8 outs after clear", {30'd0, queue_run, pio_queue_mode}, 1);

        wr(8'h04, 32'h8000_0000);
        rd_chk("R9 ctrl reads reset", 8'h00, 32'h8000_0000);
        rd_chk("R9 int cleared", 8'h10, 0);
        rd_chk("R9 qctl cleared", 8'h20, 0);
        chk("R9 soft_reset out", {31'd0, soft_reset}, 1);
        tick();
        chk("R9 irq low", {31'd0, irq}, 0);

        wr(8'h14, 32'h0000_0101);
        pulse(8'h01);
        wr(8'h24, 32'h0000_0024);
        rd_chk("R10 int ignored", 8'h10, 0);
        rd_chk("R10 qctl ignored", 8'h20, 0);
        chk("R10 irq stays low", {31'd0, irq}, 0);

        wr(8'h08, 32'h8000_0000);
        rd_chk("R10 released by clear", 8'h00, 0);
        wr(8'h14, 32'h0000_0101);
        rd_chk("R10 writes resume", 8'h10, 32'h0000_0101);
        tick();
        chk("R7 irq after release", {31'd0, irq}, 1);

        wr(8'h00, 32'h8000_0000);
        rd_chk("R9 base write reset", 8'h10, 0);
        chk("R9 base soft_reset", {31'd0, soft_reset}, 1);
        wr(8'h00, 32'h0000_0000);
        chk("R10 base release", {31'd0, soft_reset}, 0);

        wr(8'h10, 32'hFFFF_0000);
        rd_chk("R2 upper bits zero", 8'h10, 0);
        rd_chk("R11 unmapped", 8'h30, 0);

        tick(); tick();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule